// File: doc/BRIEF.md
# Auto-Baud Pulse Width Meter

This block watches a serial receive line and measures pulse widths while detection is enabled. Software reads the results and derives a baud divisor from them. It records the narrowest low pulse, the widest high pulse and the number of level changes seen since detection last began. All widths are counted in core clock cycles.

The line first passes through a two-flop synchronizer. A programmable glitch width then decides which level changes are real. A change is accepted only after the new level has held for that many consecutive cycles. Both edges of a pulse are delayed by the same filter latency, so the measured width equals the width on the line.

Each rising edge of the enable clears all three results. While enable is low, the results hold their last values and can be read at leisure.

Top module: `autobaud_meter`

## Requirements
- R1: While `meas_en` is low, `low_min`, `high_max` and `edge_cnt` hold their values whatever the line does.
- R2: Reset, and every rising edge of `meas_en`, sets `low_min` to all ones (0xFFFFF), `high_max` to 0 and `edge_cnt` to 0.
- R3: `low_min` holds the smallest width, in cycles, of any low pulse bounded by two accepted edges since detection began.
- R4: `high_max` holds the largest width, in cycles, of any high pulse bounded by two accepted edges since detection began.
- R5: `edge_cnt` increases by one for every accepted level change, rising or falling, while detection runs.
- R6: A level change is accepted only when the new level holds for at least `glitch_width` consecutive cycles, so a pulse of exactly `glitch_width` cycles counts and a shorter one does not. A value of 0 behaves like 1.
- R7: A rejected glitch neither updates the width results nor increments `edge_cnt`, and its cycles count toward the width of the pulse around it.
- R8: `edge_cnt` saturates at 1023 instead of wrapping.
- R9: The level present when detection starts is not measured, because its start is unknown. Only pulses that begin at an accepted edge are recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial receive line |
| meas_en | input | 1 | Detection enable; a rising edge restarts measurement |
| glitch_width | input | 8 | Minimum accepted pulse width in cycles |
| low_min | output | 20 | Narrowest recorded low pulse |
| high_max | output | 20 | Widest recorded high pulse |
| edge_cnt | output | 10 | Accepted level changes, saturating |

## Verification
The assertions assume that `meas_en` is low while reset is asserted. They also assume that `glitch_width` changes only while detection is disabled, so the filter threshold never moves in the middle of a pulse. The stimulus changes the threshold and the line level only between scenarios, with the enable dropped. Every pulse surrounding a glitch holds for at least the threshold on each side of the glitch, so accepted edges fall where the expected values place them.

// File: rtl/autobaud_meter.sv
module autobaud_meter #(
  parameter int WW = 20,
  parameter int EW = 10,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_i,
  input  logic          meas_en,
  input  logic [GW-1:0] glitch_width,
  output logic [WW-1:0] low_min,
  output logic [WW-1:0] high_max,
  output logic [EW-1:0] edge_cnt
);
  localparam logic [WW-1:0] WMAX = '1;
  localparam logic [EW-1:0] EMAX = '1;

  logic [1:0]    sync;
  logic          en_d, lvl, armed;
  logic [GW-1:0] cand;
  logic [WW-1:0] wcnt;

  wire rx_s    = sync[1];
  wire start   = meas_en & ~en_d;
  wire run     = meas_en & en_d;
  wire differ  = rx_s != lvl;

  wire [GW:0]   cand_next = {1'b0, cand} + 1'b1;
  wire          accept    = run && differ && (cand_next >= {1'b0, glitch_width});
  wire [WW-1:0] wcnt_inc  = (wcnt == WMAX) ? WMAX : wcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      en_d <= 1'b0;
    end else begin
      sync <= {sync[0], rxd_i};
      en_d <= meas_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl      <= 1'b1;
      armed    <= 1'b0;
      cand     <= '0;
      wcnt     <= '0;
      low_min  <= WMAX;
      high_max <= '0;
      edge_cnt <= '0;
    end else if (start) begin
      lvl      <= rx_s;
      armed    <= 1'b0;
      cand     <= '0;
      wcnt     <= '0;
      low_min  <= WMAX;
      high_max <= '0;
      edge_cnt <= '0;
    end else if (run) begin
      if (accept) begin
        lvl      <= ~lvl;
        armed    <= 1'b1;
        cand     <= '0;
        wcnt     <= '0;
        edge_cnt <= (edge_cnt == EMAX) ? EMAX : edge_cnt + 1'b1;
        if (armed && !lvl && (wcnt_inc < low_min))
          low_min <= wcnt_inc;
        if (armed && lvl && (wcnt_inc > high_max))
          high_max <= wcnt_inc;
      end else begin
        cand <= differ ? cand_next[GW-1:0] : '0;
        wcnt <= wcnt_inc;
      end
    end else begin
      lvl  <= rx_s;
      cand <= '0;
    end
  end
endmodule

module autobaud_meter_chk #(
  parameter int WW = 20,
  parameter int EW = 10,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rxd_i,
  input logic          meas_en,
  input logic [GW-1:0] glitch_width,
  input logic [WW-1:0] low_min,
  input logic [WW-1:0] high_max,
  input logic [EW-1:0] edge_cnt
);
  localparam logic [EW-1:0] EMAX = '1;

  a_r1_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> $stable(low_min) && $stable(high_max) && $stable(edge_cnt));

  a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_en) |=> (low_min == '1) && (high_max == '0) && (edge_cnt == '0));

  a_r3_min_down: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && $past(meas_en)) |=> low_min <= $past(low_min));

  a_r4_max_up: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && $past(meas_en)) |=> high_max >= $past(high_max));

  a_r5_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && $past(meas_en)) |=>
      (edge_cnt == $past(edge_cnt)) || (edge_cnt == $past(edge_cnt) + 1'b1));

  a_r8_edge_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && $past(meas_en) && edge_cnt == EMAX) |=> edge_cnt == EMAX);
endmodule

bind autobaud_meter autobaud_meter_chk #(.WW(WW), .EW(EW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .meas_en(meas_en),
  .glitch_width(glitch_width), .low_min(low_min), .high_max(high_max),
  .edge_cnt(edge_cnt)
);

// File: tb/autobaud_meter_bench.sv
module autobaud_meter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd_i = 1'b1;
  logic        meas_en = 1'b0;
  logic [7:0]  glitch_width = 8'd0;
  logic [19:0] low_min, high_max;
  logic [9:0]  edge_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [49:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  autobaud_meter u_autobaud_meter (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .meas_en(meas_en),
    .glitch_width(glitch_width), .low_min(low_min), .high_max(high_max),
    .edge_cnt(edge_cnt)
  );

  task automatic seg(input logic v, input int n);
    rxd_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] g);
    meas_en = 1'b0;
    repeat (3) @(negedge clk);
    glitch_width = g;
    meas_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_now(input logic [19:0] lo, input logic [19:0] hi,
                            input logic [9:0] ed, input string tag);
    exp_q.push_back({lo, hi, ed});
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic cmp(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [49:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "low_min",  int'(low_min),  int'(e[49:30]));
        cmp(t, "high_max", int'(high_max), int'(e[29:10]));
        cmp(t, "edge_cnt", int'(edge_cnt), int'(e[9:0]));
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(20'hFFFFF, 20'd0, 10'd0, "R2 reset");

    // R3 R4 R5: clean pulses with threshold 3
    restart(8'd3);
    seg(1'b1, 10);
    seg(1'b0, 7); seg(1'b1, 12); seg(1'b0, 5); seg(1'b1, 20); seg(1'b0, 9);
    seg(1'b1, 30);
    expect_now(20'd5, 20'd20, 10'd6, "R3 R4 R5 clean pulses");

    // R1: line activity while disabled is ignored
    meas_en = 1'b0;
    repeat (3) @(negedge clk);
    seg(1'b0, 2); seg(1'b1, 2); seg(1'b0, 30); seg(1'b1, 40);
    expect_now(20'd5, 20'd20, 10'd6, "R1 disabled hold");

    // R2: restart clears results
    restart(8'd4);
    expect_now(20'hFFFFF, 20'd0, 10'd0, "R2 enable rise clear");

    // R6 R7: glitches inside pulses, pulse of exactly the threshold
    seg(1'b1, 20);
    seg(1'b0, 8);
    seg(1'b1, 6); seg(1'b0, 3); seg(1'b1, 6);
    seg(1'b0, 5); seg(1'b1, 2); seg(1'b0, 5);
    seg(1'b1, 11);
    seg(1'b0, 4);
    seg(1'b1, 30);
    expect_now(20'd4, 20'd15, 10'd6, "R6 R7 glitch filter");

    // R6: only sub-threshold pulses leave results untouched
    restart(8'd5);
    seg(1'b1, 10); seg(1'b0, 4); seg(1'b1, 10); seg(1'b0, 4); seg(1'b1, 30);
    expect_now(20'hFFFFF, 20'd0, 10'd0, "R6 R7 short pulses rejected");

    // R6: threshold 0 accepts single-cycle pulses
    restart(8'd0);
    seg(1'b1, 10);
    seg(1'b0, 1); seg(1'b1, 1); seg(1'b0, 2); seg(1'b1, 3); seg(1'b0, 1);
    seg(1'b1, 20);
    expect_now(20'd1, 20'd3, 10'd6, "R6 zero threshold");

    // R9: level present at start is not measured
    meas_en = 1'b0;
    seg(1'b0, 10);
    glitch_width = 8'd2;
    meas_en = 1'b1;
    seg(1'b0, 40);
    seg(1'b1, 9); seg(1'b0, 6); seg(1'b1, 30);
    expect_now(20'd6, 20'd9, 10'd3, "R9 partial first pulse");

    // R8: edge count saturates
    restart(8'd1);
    seg(1'b1, 10);
    for (int i = 0; i < 600; i++) begin
      seg(1'b0, 1);
      seg(1'b1, 1);
    end
    seg(1'b1, 20);
    expect_now(20'd1, 20'd1, 10'd1023, "R8 edge saturation");

    // R1: a long low pulse while disabled leaves saturated results
    meas_en = 1'b0;
    repeat (2) @(negedge clk);
    seg(1'b0, 15); seg(1'b1, 15);
    expect_now(20'd1, 20'd1, 10'd1023, "R1 disabled after saturation");

    finish_run();
  end
endmodule